// File: doc/BRIEF.md
# Weighted Constrained-Random Bus Transaction Generator

This block is a hardware source of bus transaction records for stress testing an AHB-style interconnect. Every record carries a direction, a burst code, a transfer size, a protection code, a length, a start address, a data word and a pre-delay, which is the same set of fields a transaction replay master takes as input. A 32-bit linear feedback shift register supplies all the random bits. It is loaded from a seed input while reset is held, so a given seed always yields the same stream of records.

Every record follows one of two fixed profiles. The read profile keeps its fields small and its addresses in the lowest 256 bytes. The write profile produces incrementing or wrapping bursts of words in the next 256 bytes. The write profile is chosen twice as often as the read profile. The record is assembled one field per clock, so each record takes a fixed number of cycles. The finished record is then presented on a valid/ready port and held there until it is taken.

Top module: `ahb_rand_gen`

## Requirements
- R1: While rst_n is low, out_valid is 0 and the random register is loaded from seed. A seed of zero is replaced by the constant 32'hACE1_0001, so the register never holds zero.
- R2: out_valid first rises at the 8th rising clock edge after rst_n is released. After each accepted record (out_valid and out_ready both 1 at an edge), out_valid is 0 for the next 7 edges and rises at the 8th.
- R3: While out_valid is 1 and out_ready is 0, out_valid stays 1 and every record field stays unchanged.
- R4: A read record (rec_write = 0) has rec_burst in {0,1}, rec_size in {0,1}, rec_len in 1..255, rec_prot in 1..15 and rec_addr in 0x000..0x0FF.
- R5: A write record (rec_write = 1) has rec_burst in 2..7, rec_size = 2, rec_len = 0, rec_prot = 0 and rec_addr in 0x100..0x1FF.
- R6: In both profiles rec_pre_delay is 0 or 1.
- R7: The profile is selected by the random word modulo 3: a remainder of 0 gives a read, and 1 or 2 gives a write. Over a long run, roughly one third of the records are reads.
- R8: Resetting with the same seed reproduces the same record sequence. Two different seeds give different sequences.
- R9: rec_data is unconstrained. Over a long run every one of its bits is seen both as 0 and as 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| seed | input | 32 | Starting value for the random register, sampled during reset |
| out_valid | output | 1 | A complete record is presented |
| out_ready | input | 1 | The consumer accepts the record at this edge |
| rec_write | output | 1 | 1 = write profile, 0 = read profile |
| rec_burst | output | 3 | Burst type code |
| rec_size | output | 2 | Transfer size code |
| rec_prot | output | 4 | Protection code |
| rec_len | output | 10 | Transfer length |
| rec_addr | output | 32 | Start address |
| rec_data | output | 32 | Data word |
| rec_pre_delay | output | 32 | Idle cycles before the transaction |

## Verification
A selector decision taken from the wrong remainder shows up as a read/write ratio far from one third within a few hundred records. A field mapped with the wrong offset or modulus shows up as an out-of-profile value on the first record of that profile, at most a few records after reset. A sequencing counter that is off by one changes the count of idle cycles between handshakes on the very first record. A random register that advances while the record is stalled, or that is not loaded from the seed, breaks either the held fields during a stall or the record-for-record reproduction after a second reset.

// File: rtl/agen_pkg.sv
package agen_pkg;

   localparam int NUM_FIELDS = 8;

   typedef enum logic [2:0] {
      FLD_SEL   = 3'd0,
      FLD_BURST = 3'd1,
      FLD_SIZE  = 3'd2,
      FLD_LEN   = 3'd3,
      FLD_PROT  = 3'd4,
      FLD_ADDR  = 3'd5,
      FLD_DATA  = 3'd6,
      FLD_PDLY  = 3'd7
   } field_e;

   typedef enum logic {
      ST_BUILD = 1'b0,
      ST_OFFER = 1'b1
   } gen_state_e;

endpackage

// File: rtl/agen_lfsr.sv
module agen_lfsr #(
   parameter int          W        = 32,
   parameter logic [W-1:0] TAPS     = 32'hA300_0000,
   parameter bit          GALOIS   = 1'b1,
   parameter logic [W-1:0] ZERO_SUB = 32'hACE1_0001
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] seed_i,
   input  logic         adv_i,
   output logic [W-1:0] state_o
);

   logic [W-1:0] nxt;

   if (W < 16) begin : g_bad_w
      $error("agen_lfsr: W must be at least 16");
   end
   if (ZERO_SUB == '0) begin : g_bad_sub
      $error("agen_lfsr: ZERO_SUB must be nonzero");
   end

   if (GALOIS) begin : g_galois
      always_comb nxt = {1'b0, state_o[W-1:1]} ^ (state_o[0] ? TAPS : '0);
   end else begin : g_fibo
      always_comb nxt = {state_o[W-2:0], ^(state_o & TAPS)};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     state_o <= (seed_i == '0) ? ZERO_SUB : seed_i;
      else if (adv_i) state_o <= nxt;
   end

   AST_LFSR_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
      state_o != '0); // R1
   AST_LFSR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !adv_i |=> $stable(state_o)); // R8

endmodule

// File: rtl/agen_field_pick.sv
// Maps one random word onto every field of both profiles. A range is reduced by
// modulo, so a span of N values carries a bias of at most N / 2^W, which is
// negligible for W = 32.
module agen_field_pick #(
   parameter int W      = 32,
   parameter int LEN_W  = 10,
   parameter int ADDR_W = 32,
   parameter int DATA_W = 32,
   parameter int DLY_W  = 32
) (
   input  logic [W-1:0]      rnd_i,
   input  logic              read_set_i,
   output logic              sel_read_o,
   output logic [2:0]        burst_o,
   output logic [1:0]        size_o,
   output logic [LEN_W-1:0]  len_o,
   output logic [3:0]        prot_o,
   output logic [ADDR_W-1:0] addr_o,
   output logic [DATA_W-1:0] data_o,
   output logic [DLY_W-1:0]  dly_o
);

   logic [W-1:0] m3, m6, m15, m255;

   always_comb begin
      m3   = rnd_i % W'(3);
      m6   = rnd_i % W'(6);
      m15  = rnd_i % W'(15);
      m255 = rnd_i % W'(255);

      sel_read_o = (m3 == '0);
      data_o     = rnd_i[DATA_W-1:0];
      dly_o      = DLY_W'(rnd_i[0]);

      if (read_set_i) begin
         burst_o = {2'b00, rnd_i[0]};
         size_o  = {1'b0, rnd_i[0]};
         len_o   = LEN_W'(m255[7:0]) + LEN_W'(1);
         prot_o  = m15[3:0] + 4'd1;
         addr_o  = ADDR_W'(rnd_i[7:0]);
      end else begin
         burst_o = m6[2:0] + 3'd2;
         size_o  = 2'd2;
         len_o   = '0;
         prot_o  = 4'd0;
         addr_o  = ADDR_W'({1'b1, rnd_i[7:0]});
      end
   end

endmodule

// File: rtl/ahb_rand_gen.sv
module ahb_rand_gen
   import agen_pkg::*;
#(
   parameter int           LFSR_W      = 32,
   parameter logic [31:0]  LFSR_TAPS   = 32'hA300_0000,
   parameter bit           LFSR_GALOIS = 1'b1,
   parameter logic [31:0]  SEED_ZERO   = 32'hACE1_0001,
   parameter int           LEN_W       = 10,
   parameter int           ADDR_W      = 32,
   parameter int           DATA_W      = 32,
   parameter int           DLY_W       = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [LFSR_W-1:0] seed,
   output logic              out_valid,
   input  logic              out_ready,
   output logic              rec_write,
   output logic [2:0]        rec_burst,
   output logic [1:0]        rec_size,
   output logic [3:0]        rec_prot,
   output logic [LEN_W-1:0]  rec_len,
   output logic [ADDR_W-1:0] rec_addr,
   output logic [DATA_W-1:0] rec_data,
   output logic [DLY_W-1:0]  rec_pre_delay
);

   localparam logic [2:0] LAST_FLD = 3'(NUM_FIELDS - 1);

   if (DATA_W > LFSR_W) begin : g_bad_data
      $error("ahb_rand_gen: DATA_W exceeds LFSR_W");
   end
   if (ADDR_W < 9 || LEN_W < 8) begin : g_bad_fields
      $error("ahb_rand_gen: ADDR_W >= 9 and LEN_W >= 8 required");
   end

   gen_state_e        state_q;
   logic [2:0]        fld_q;
   logic              is_read_q;
   logic              adv;
   logic [LFSR_W-1:0] rnd;

   logic              p_sel;
   logic [2:0]        p_burst;
   logic [1:0]        p_size;
   logic [LEN_W-1:0]  p_len;
   logic [3:0]        p_prot;
   logic [ADDR_W-1:0] p_addr;
   logic [DATA_W-1:0] p_data;
   logic [DLY_W-1:0]  p_dly;

   assign adv       = (state_q == ST_BUILD);
   assign out_valid = (state_q == ST_OFFER);
   assign rec_write = ~is_read_q;

   agen_lfsr #(
      .W(LFSR_W), .TAPS(LFSR_TAPS), .GALOIS(LFSR_GALOIS), .ZERO_SUB(SEED_ZERO)
   ) u_lfsr (
      .clk(clk), .rst_n(rst_n), .seed_i(seed), .adv_i(adv), .state_o(rnd)
   );

   agen_field_pick #(
      .W(LFSR_W), .LEN_W(LEN_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .DLY_W(DLY_W)
   ) u_pick (
      .rnd_i(rnd), .read_set_i(is_read_q), .sel_read_o(p_sel),
      .burst_o(p_burst), .size_o(p_size), .len_o(p_len), .prot_o(p_prot),
      .addr_o(p_addr), .data_o(p_data), .dly_o(p_dly)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q       <= ST_BUILD;
         fld_q         <= '0;
         is_read_q     <= 1'b0;
         rec_burst     <= '0;
         rec_size      <= '0;
         rec_len       <= '0;
         rec_prot      <= '0;
         rec_addr      <= '0;
         rec_data      <= '0;
         rec_pre_delay <= '0;
      end else if (state_q == ST_BUILD) begin
         case (field_e'(fld_q))
            FLD_SEL:   is_read_q     <= p_sel;
            FLD_BURST: rec_burst     <= p_burst;
            FLD_SIZE:  rec_size      <= p_size;
            FLD_LEN:   rec_len       <= p_len;
            FLD_PROT:  rec_prot      <= p_prot;
            FLD_ADDR:  rec_addr      <= p_addr;
            FLD_DATA:  rec_data      <= p_data;
            FLD_PDLY:  rec_pre_delay <= p_dly;
            default:   ;
         endcase
         if (fld_q == LAST_FLD) begin
            fld_q   <= '0;
            state_q <= ST_OFFER;
         end else begin
            fld_q <= fld_q + 3'd1;
         end
      end else if (out_ready) begin
         state_q <= ST_BUILD;
      end
   end

   AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_ready |=> out_valid && $stable({rec_write, rec_burst,
      rec_size, rec_prot, rec_len, rec_addr, rec_data, rec_pre_delay})); // R3
   AST_DROP_AFTER_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && out_ready |=> !out_valid); // R2
   AST_BUILD_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(out_valid) |-> $past(fld_q) == LAST_FLD); // R2
   AST_READ_PROFILE: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !rec_write |-> rec_burst <= 3'd1 && rec_size <= 2'd1 &&
      rec_len >= LEN_W'(1) && rec_len <= LEN_W'(255) && rec_prot != 4'd0 &&
      rec_addr <= ADDR_W'(255)); // R4
   AST_WRITE_PROFILE: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && rec_write |-> rec_burst >= 3'd2 && rec_size == 2'd2 &&
      rec_len == '0 && rec_prot == 4'd0 && rec_addr >= ADDR_W'(256) &&
      rec_addr <= ADDR_W'(511)); // R5
   AST_PREDELAY: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> rec_pre_delay <= DLY_W'(1)); // R6

endmodule

// File: tb/ahb_rand_gen_bench.sv
`timescale 1ns/1ps
module ahb_rand_gen_bench;

   localparam int          RECW     = 116;
   localparam logic [31:0] ZSUB     = 32'hACE1_0001;
   localparam logic [31:0] SEED_A   = 32'h1234_5678;
   localparam logic [31:0] SEED_B   = 32'h0BAD_F00D;
   localparam int          N_RUN    = 300;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] seed = SEED_A;
   logic        out_ready = 1'b0;
   logic        out_valid, rec_write;
   logic [2:0]  rec_burst;
   logic [1:0]  rec_size;
   logic [3:0]  rec_prot;
   logic [9:0]  rec_len;
   logic [31:0] rec_addr, rec_data, rec_pre_delay;

   int errors = 0;
   int checks = 0;

   always #2.5 clk = ~clk;

   ahb_rand_gen u_ahb_rand_gen (
      .clk(clk), .rst_n(rst_n), .seed(seed), .out_valid(out_valid),
      .out_ready(out_ready), .rec_write(rec_write), .rec_burst(rec_burst),
      .rec_size(rec_size), .rec_prot(rec_prot), .rec_len(rec_len),
      .rec_addr(rec_addr), .rec_data(rec_data), .rec_pre_delay(rec_pre_delay)
   );

   function automatic logic [RECW-1:0] cur_rec();
      return {rec_write, rec_burst, rec_size, rec_prot, rec_len,
              rec_addr, rec_data, rec_pre_delay};
   endfunction

   // Expected profile legality, written from R4, R5 and R6.
   function automatic bit profile_ok(logic [RECW-1:0] r);
      logic w; logic [2:0] b; logic [1:0] s; logic [3:0] p; logic [9:0] l;
      logic [31:0] a, d, pd;
      {w, b, s, p, l, a, d, pd} = r;
      if (pd > 32'd1) return 1'b0;
      if (!w) return b <= 3'd1 && s <= 2'd1 && l >= 10'd1 && l <= 10'd255 &&
                     p >= 4'd1 && a <= 32'h0FF;
      return b >= 3'd2 && s == 2'd2 && l == 10'd0 && p == 4'd0 &&
             a >= 32'h100 && a <= 32'h1FF;
   endfunction

   task automatic check(input bit ok, input string req, input logic [RECW-1:0] act,
                        input logic [RECW-1:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic do_reset(input logic [31:0] s);
      @(negedge clk);
      rst_n = 1'b0; seed = s; out_ready = 1'b0;
      @(negedge clk);
      check(out_valid == 1'b0, "R1 valid low in reset", RECW'(out_valid), '0);
      rst_n = 1'b1;
   endtask

   // Counts negedge samples with out_valid low before it rises; R2 expects 7.
   task automatic gap(output int n);
      n = 0;
      forever begin
         @(negedge clk);
         if (out_valid) break;
         n++;
      end
   endtask

   // Takes one presented record after a random stall, checking R3 while stalled.
   task automatic take(input int stall_max, output logic [RECW-1:0] rec);
      int stalls;
      logic [RECW-1:0] held;
      stalls = $urandom_range(stall_max, 0);
      held = cur_rec();
      while (stalls > 0) begin
         @(negedge clk);
         check(out_valid && cur_rec() == held, "R3 stall hold", cur_rec(), held);
         stalls--;
      end
      rec = cur_rec();
      out_ready = 1'b1;
      @(negedge clk);
      out_ready = 1'b0;
   endtask

   initial begin
      #500us;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      logic [RECW-1:0] first_a [5];
      logic [RECW-1:0] r;
      logic [31:0] seen1, seen0;
      int n, reads;
      bit same, differs;

      void'($urandom(32'd2024));

      // R1, R2: reset state and first record latency
      do_reset(SEED_A);
      gap(n);
      check(n == 7, "R2 first latency", RECW'(n), RECW'(7));

      // Main run with random stalls: R3..R7, R9
      reads = 0; seen1 = '0; seen0 = '0;
      for (int i = 0; i < N_RUN; i++) begin
         take(3, r);
         if (i < 5) first_a[i] = r;
         check(profile_ok(r), r[RECW-1] ? "R5 write profile" : "R4 read profile R6",
               r, '0);
         if (!r[RECW-1]) reads++;
         seen1 |= r[63:32];
         seen0 |= ~r[63:32];
         gap(n);
         if (i < 6) check(n == 7, "R2 gap after take", RECW'(n), RECW'(7));
      end
      check(reads >= 75 && reads <= 125, "R7 read share near 1/3",
            RECW'(reads), RECW'(N_RUN / 3));
      check(seen1 == '1 && seen0 == '1, "R9 data bits toggle",
            RECW'({seen1, seen0}), {RECW{1'b1}});

      // R8: same seed reproduces, other seed differs
      do_reset(SEED_A);
      gap(n);
      for (int i = 0; i < 5; i++) begin
         take(2, r);
         check(r == first_a[i], "R8 reproduce", r, first_a[i]);
         gap(n);
      end
      do_reset(SEED_B);
      gap(n);
      differs = 1'b0;
      for (int i = 0; i < 5; i++) begin
         take(0, r);
         if (r != first_a[i]) differs = 1'b1;
         gap(n);
      end
      check(differs, "R8 other seed differs", RECW'(differs), RECW'(1));

      // R1: zero seed behaves as the substitute constant
      do_reset(32'h0);
      gap(n);
      for (int i = 0; i < 5; i++) begin
         take(0, r);
         first_a[i] = r;
         gap(n);
      end
      do_reset(ZSUB);
      gap(n);
      same = 1'b1;
      for (int i = 0; i < 5; i++) begin
         take(1, r);
         if (r != first_a[i]) same = 1'b0;
         gap(n);
      end
      check(same, "R1 zero seed substitute", RECW'(same), RECW'(1));
      check(first_a[0] != first_a[1] || first_a[1] != first_a[2],
            "R1 zero seed not stuck", first_a[1], first_a[0]);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule